// File: doc/BRIEF.md
# Kernel Cache Invalidate and Writeback Tracker

This block follows the cache-maintenance progress of a single kernel. It keeps two signed counters. The invalidate counter covers three phases with one value. All ones (-1) means the invalidate phase has not begun. Zero means it has finished. Any positive value is the number of invalidate requests still in flight. The writeback counter starts at zero and counts writeback requests still in flight.

Each counter has an issue port and a response port, and each port carries a signed delta. Whatever arrives in one cycle is summed and applied as one registered update. The block refuses any update whose result would leave the legal range. The counter then keeps its old value, and an error flag pulses for one cycle. A force-done command moves the invalidate phase straight to finished.

All pins are plain control and status. There is no streamed data, so there is no valid/ready back-pressure: every update is taken or refused in the cycle it is presented. The cache operations themselves are produced elsewhere.

Top module: `kcache_sync_tracker`

## Requirements
- R1: After reset, inv_count is -1, wb_count is 0, and inv_started, inv_done, inv_err, wb_done and wb_err are all 0.
- R2: inv_started is 1 exactly when inv_count differs from -1. inv_done is 1 exactly when inv_count is 0. Once inv_started is 1, it stays 1 until the next reset.
- R3: When either invalidate valid is high and force is low, the sum of the deltas presented (a port whose valid is low adds 0) is added to inv_count. The new value appears one clock edge later.
- R4: inv_force_done sets inv_count to 0 at the next edge. It overrides any invalidate deltas in the same cycle and raises no error.
- R5: If an invalidate update would give a result below 0, inv_count keeps its value and inv_err is 1 for exactly the following cycle. This includes a zero-sum update while the count is still -1.
- R6: If an update to either counter would give a result above 32767, the largest value of a 16-bit signed counter, the counter keeps its value and that counter's error flag pulses for one cycle.
- R7: wb_count resets to 0 and takes summed signed deltas by the same rule. A result below 0 is refused, wb_count holds, and wb_err pulses for one cycle.
- R8: An issue and a response presented in the same cycle are combined before the range check, so only their sum has to be legal.
- R9: wb_done is 1 when wb_count is 0 and wb_count was nonzero in some earlier cycle since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inv_issue_vld | input | 1 | Invalidate issue delta present |
| inv_issue_delta | input | DELTA_W | Signed invalidate issue delta |
| inv_resp_vld | input | 1 | Invalidate response delta present |
| inv_resp_delta | input | DELTA_W | Signed invalidate response delta |
| inv_force_done | input | 1 | Force invalidate phase to finished |
| wb_issue_vld | input | 1 | Writeback issue delta present |
| wb_issue_delta | input | DELTA_W | Signed writeback issue delta |
| wb_resp_vld | input | 1 | Writeback response delta present |
| wb_resp_delta | input | DELTA_W | Signed writeback response delta |
| inv_count | output | CNT_W | Signed invalidate counter |
| inv_started | output | 1 | Invalidate phase has begun |
| inv_done | output | 1 | Invalidate phase finished |
| inv_err | output | 1 | Invalidate update refused (one-cycle pulse) |
| wb_count | output | CNT_W | Signed writeback counter |
| wb_done | output | 1 | All issued writebacks have completed |
| wb_err | output | 1 | Writeback update refused (one-cycle pulse) |

## Verification
inv_count, wb_count and both error flags all change at the first rising edge after the stimulus. inv_started, inv_done and wb_done follow from the registered counters without delay, so they are also valid in that cycle. wb_done can rise no sooner than the edge at which wb_count returns to zero. The bench drives each stimulus on a falling edge and compares every output at the next falling edge against its own arithmetic model, which is half a clock after the edge that was expected to update it.

// File: rtl/ksync_pkg.sv
package ksync_pkg;
  // Default counter width shared by the tracker and its checker
  parameter int KSYNC_CNT_W = 16;
  // Sentinel held by the invalidate counter before the phase begins
  parameter int INV_NOT_STARTED = -1;
  // Writeback counter starting value
  parameter int WB_START = 0;
endpackage

// File: rtl/ksync_delta_counter.sv
module ksync_delta_counter #(
  parameter int CNT_W     = 16,
  parameter int DELTA_W   = 16,
  parameter int RESET_VAL = 0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      a_vld,
  input  logic signed [DELTA_W-1:0] a_delta,
  input  logic                      b_vld,
  input  logic signed [DELTA_W-1:0] b_delta,
  input  logic                      force_zero,
  output logic signed [CNT_W-1:0]   count,
  output logic                      reject
);
  // Two guard bits keep the sum of a count and two deltas exact
  localparam int SUM_W = CNT_W + 2;
  localparam logic signed [SUM_W-1:0] CNT_MAX = {3'b000, {(CNT_W-1){1'b1}}};
  localparam logic signed [CNT_W-1:0] RST_VAL = CNT_W'(RESET_VAL);

  logic signed [SUM_W-1:0] ext_cnt, ext_a, ext_b, result;
  logic                    any_vld, under, over;

  always_comb begin
    ext_cnt = $signed({{2{count[CNT_W-1]}}, count});
    ext_a   = a_vld ? $signed({{(SUM_W-DELTA_W){a_delta[DELTA_W-1]}}, a_delta}) : '0;
    ext_b   = b_vld ? $signed({{(SUM_W-DELTA_W){b_delta[DELTA_W-1]}}, b_delta}) : '0;
    result  = ext_cnt + ext_a + ext_b;
    any_vld = a_vld | b_vld;
    under   = result < 0;
    over    = result > CNT_MAX;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= RST_VAL;
      reject <= 1'b0;
    end else if (force_zero) begin
      count  <= '0;
      reject <= 1'b0;
    end else if (any_vld && (under || over)) begin
      reject <= 1'b1;
    end else begin
      reject <= 1'b0;
      if (any_vld) count <= result[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/kcache_sync_tracker.sv
module kcache_sync_tracker #(
  parameter int CNT_W   = ksync_pkg::KSYNC_CNT_W,
  parameter int DELTA_W = CNT_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      inv_issue_vld,
  input  logic signed [DELTA_W-1:0] inv_issue_delta,
  input  logic                      inv_resp_vld,
  input  logic signed [DELTA_W-1:0] inv_resp_delta,
  input  logic                      inv_force_done,
  input  logic                      wb_issue_vld,
  input  logic signed [DELTA_W-1:0] wb_issue_delta,
  input  logic                      wb_resp_vld,
  input  logic signed [DELTA_W-1:0] wb_resp_delta,
  output logic signed [CNT_W-1:0]   inv_count,
  output logic                      inv_started,
  output logic                      inv_done,
  output logic                      inv_err,
  output logic signed [CNT_W-1:0]   wb_count,
  output logic                      wb_done,
  output logic                      wb_err
);
  localparam logic signed [CNT_W-1:0] INV_IDLE_VAL = CNT_W'(ksync_pkg::INV_NOT_STARTED);

  logic wb_seen;

  ksync_delta_counter #(
    .CNT_W(CNT_W), .DELTA_W(DELTA_W), .RESET_VAL(ksync_pkg::INV_NOT_STARTED)
  ) u_inv_cnt (
    .clk(clk), .rst_n(rst_n),
    .a_vld(inv_issue_vld), .a_delta(inv_issue_delta),
    .b_vld(inv_resp_vld),  .b_delta(inv_resp_delta),
    .force_zero(inv_force_done),
    .count(inv_count), .reject(inv_err)
  );

  ksync_delta_counter #(
    .CNT_W(CNT_W), .DELTA_W(DELTA_W), .RESET_VAL(ksync_pkg::WB_START)
  ) u_wb_cnt (
    .clk(clk), .rst_n(rst_n),
    .a_vld(wb_issue_vld), .a_delta(wb_issue_delta),
    .b_vld(wb_resp_vld),  .b_delta(wb_resp_delta),
    .force_zero(1'b0),
    .count(wb_count), .reject(wb_err)
  );

  // Remember that writebacks were ever outstanding
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wb_seen <= 1'b0;
    else if (wb_count != '0) wb_seen <= 1'b1;
  end

  always_comb begin
    inv_started = inv_count != INV_IDLE_VAL;
    inv_done    = inv_count == '0;
    wb_done     = wb_seen && (wb_count == '0);
  end
endmodule

// File: rtl/kcache_sync_tracker_chk.sv
module kcache_sync_tracker_chk #(
  parameter int CNT_W = ksync_pkg::KSYNC_CNT_W
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    inv_force_done,
  input logic signed [CNT_W-1:0] inv_count,
  input logic                    inv_started,
  input logic                    inv_err,
  input logic signed [CNT_W-1:0] wb_count,
  input logic                    wb_done,
  input logic                    wb_err
);
  p_inv_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inv_count >= -1);
  p_stays_started_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inv_started) |-> inv_started);
  p_force_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    inv_force_done |=> (inv_count == 0));
  p_inv_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inv_err |-> $stable(inv_count));
  p_wb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_err |-> $stable(wb_count));
  p_wb_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_count >= 0);
  p_wb_done_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_done) |-> ($past(wb_count) != 0));
endmodule

bind kcache_sync_tracker kcache_sync_tracker_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .inv_force_done(inv_force_done),
  .inv_count(inv_count), .inv_started(inv_started), .inv_err(inv_err),
  .wb_count(wb_count), .wb_done(wb_done), .wb_err(wb_err)
);

// File: tb/kcache_sync_tracker_tb.sv
module kcache_sync_tracker_tb;
  localparam int CNT_W = 16;
  localparam int CMAX  = 32767;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iv = 0, rv = 0, fd = 0, wv = 0, wrv = 0;
  logic signed [CNT_W-1:0] idl = '0, rdl = '0, wdl = '0, wrdl = '0;
  logic signed [CNT_W-1:0] inv_count, wb_count;
  logic inv_started, inv_done, inv_err, wb_done, wb_err;

  int n_chk = 0, n_bad = 0;
  int m_inv, m_wb;
  bit m_ierr, m_werr, m_seen, finished = 0;

  always #4 clk = ~clk;

  kcache_sync_tracker #(.CNT_W(CNT_W), .DELTA_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .inv_issue_vld(iv), .inv_issue_delta(idl),
    .inv_resp_vld(rv), .inv_resp_delta(rdl),
    .inv_force_done(fd),
    .wb_issue_vld(wv), .wb_issue_delta(wdl),
    .wb_resp_vld(wrv), .wb_resp_delta(wrdl),
    .inv_count(inv_count), .inv_started(inv_started), .inv_done(inv_done),
    .inv_err(inv_err), .wb_count(wb_count), .wb_done(wb_done), .wb_err(wb_err)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({"R3 ", tag}, "inv_count", int'(inv_count), m_inv);
    chk({"R2 ", tag}, "inv_started", int'(inv_started), int'(m_inv != -1));
    chk({"R2 ", tag}, "inv_done", int'(inv_done), int'(m_inv == 0));
    chk({"R5 ", tag}, "inv_err", int'(inv_err), int'(m_ierr));
    chk({"R7 ", tag}, "wb_count", int'(wb_count), m_wb);
    chk({"R7 ", tag}, "wb_err", int'(wb_err), int'(m_werr));
    chk({"R9 ", tag}, "wb_done", int'(wb_done), int'(m_seen && m_wb == 0));
  endtask

  task automatic do_reset();
    rst_n = 0; iv = 0; rv = 0; fd = 0; wv = 0; wrv = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_inv = -1; m_wb = 0; m_ierr = 0; m_werr = 0; m_seen = 0;
    @(negedge clk);
    check_all("R1 reset");
  endtask

  // Drive on a falling edge, let one rising edge pass, compare on the next falling edge
  task automatic apply(input bit a, input int ad, input bit b, input int bd, input bit f,
                       input bit c, input int cd, input bit d, input int dd, input string tag);
    int res;
    iv = a; idl = CNT_W'(ad); rv = b; rdl = CNT_W'(bd); fd = f;
    wv = c; wdl = CNT_W'(cd); wrv = d; wrdl = CNT_W'(dd);
    @(posedge clk);
    if (f) begin m_inv = 0; m_ierr = 0; end
    else if (a || b) begin
      res = m_inv + (a ? ad : 0) + (b ? bd : 0);
      if (res < 0 || res > CMAX) m_ierr = 1;
      else begin m_inv = res; m_ierr = 0; end
    end else m_ierr = 0;
    if (m_wb != 0) m_seen = 1;
    if (c || d) begin
      res = m_wb + (c ? cd : 0) + (d ? dd : 0);
      if (res < 0 || res > CMAX) m_werr = 1;
      else begin m_wb = res; m_werr = 0; end
    end else m_werr = 0;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle();
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R5: a zero-sum update while the count is still -1 is refused
    apply(1, 0, 0, 0, 0, 0, 0, 0, 0, "R5 zero from idle");
    idle();
    apply(1, 3, 0, 0, 0, 1, 3, 0, 0, "R3 first issue");
    apply(0, 0, 1, -2, 0, 0, 0, 1, -3, "R9 wb drain");
    idle();
    apply(1, 5, 1, -1, 1, 0, 0, 0, 0, "R4 force over deltas");
    apply(1, CMAX, 0, 0, 0, 1, CMAX, 0, 0, "R6 to max");
    apply(1, 1, 0, 0, 0, 1, 1, 0, 0, "R6 overflow");
    apply(1, 4, 1, -4, 0, 1, 2, 1, -2, "R8 combined at max");
    apply(0, 0, 1, -32768, 0, 0, 0, 1, -32768, "R5 underflow");
    apply(1, 2, 1, -3, 0, 1, 1, 1, -32767, "R8 combined net");
    do_reset();
    // Near-exhaustive sweep of valid pairs and small deltas
    for (int k = 0; k < 4; k++) begin
      for (int di = -3; di <= 3; di++) begin
        for (int dr = -3; dr <= 3; dr++) begin
          apply(k[0], di, k[1], dr, ((di + 3) * 7 + dr + 3 + k) % 23 == 7,
                k[1], dr + 1, k[0], -di, "R8 sweep");
        end
      end
    end
    do_reset();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule